// File: doc/BRIEF.md
# Keyboard Controller Host Command Processor

This block sits between a host's byte-wide register bus and the two device channels of a PC-style keyboard/mouse controller. The host writes to one of two addresses: the command port carries one-byte controller commands, and the data port carries data bytes. Some commands act at once: they reply with a byte on the keyboard response channel, set or clear mode bits, or move the A20 gate. Others only arm a pending target that decides where the next data-port byte lands. That byte goes to the mode register, the output port, either response queue, or the mouse device.

The block holds the controller mode register, the status register and the output port, and presents them as levels for neighbouring logic. All enqueue, forward, reset-request and error indications are single-cycle strobes registered on the clock edge that samples the host write, and they share one byte bus. The serial line protocol, the device-side command handling and the scan-code translation itself lie outside it.

Top module: `kbc_host_if`

## Requirements
- R1: After reset, mode_q = 0x03, status_q = 0x18, outport_q = 0xCF, a20_gate = 1, xlat_en = 0, no pending target and every strobe low.
- R2: A command-port write of 0x20 pulses kbd_enq with out_byte equal to the mode register value held before the write.
- R3: Command bytes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 raise no strobe and only arm a pending target. A following data write of 0xD2 pulses kbd_enq with the data. 0xD3 pulses aux_enq with the data. 0xD4 pulses mouse_fwd with the data. The target is disarmed by that data write, so the next data write is forwarded per R4.
- R4: A data-port write with no pending target pulses kbd_fwd with out_byte equal to the data.
- R5: Command 0xA7 sets and 0xA8 clears mode bit 5. Command 0xAD sets and 0xAE clears mode bit 4. No other mode bit changes and no strobe fires.
- R6: Commands 0xA9 and 0xAB enqueue 0x00 on kbd_enq. Command 0xC0 enqueues 0x80. Command 0xD0 enqueues the current outport_q. Command 0xAA sets status bit 2 and enqueues 0x55. No other status bit ever changes from its reset value.
- R7: Any command byte with bits 7:4 = 0xF is a pulse command. It pulses sys_rst_req when bit 0 is 0, and otherwise has no effect.
- R8: Command 0xDF sets a20_gate and outport_q bit 1. Command 0xDD clears both. a20_gate always equals outport_q bit 1.
- R9: A data write armed by 0xD1 loads outport_q, sets a20_gate from data bit 1, and pulses sys_rst_req when data bit 0 is 0.
- R10: A data write armed by 0xD1's sibling 0x60 loads mode_q and sets xlat_en from data bit 6. xlat_en always equals mode_q bit 6.
- R11: A command byte outside the recognised set pulses bad_cmd and changes no register and no pending target.
- R12: At most one of kbd_enq, aux_enq, kbd_fwd, mouse_fwd and bad_cmd is high in any cycle. All strobes are low in the cycle after a cycle with no host write. out_byte is 0 when no byte strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_sel_cmd | input | 1 | 1 selects the command port, 0 the data port |
| host_wdata | input | 8 | Written byte |
| kbd_enq | output | 1 | Enqueue out_byte on the keyboard response channel |
| aux_enq | output | 1 | Enqueue out_byte on the auxiliary response channel |
| kbd_fwd | output | 1 | Forward out_byte to the keyboard device |
| mouse_fwd | output | 1 | Forward out_byte to the mouse device |
| out_byte | output | 8 | Byte carried by the current enqueue or forward strobe |
| sys_rst_req | output | 1 | System reset request strobe |
| bad_cmd | output | 1 | Unrecognised command strobe |
| a20_gate | output | 1 | A20 gate level |
| xlat_en | output | 1 | Scan-code translation enable |
| mode_q | output | 8 | Mode register |
| status_q | output | 8 | Status register |
| outport_q | output | 8 | Output port register |

## Verification
The hardest state to reach is a pending target that survives intervening command writes. This happens when an arming command is followed by an unrecognised, pulse or immediate command before the data byte arrives. The data byte must then still be steered to the armed target. The random phase interleaves arming commands, arbitrary command bytes and data writes with no ordering constraint, so these interleavings arise often. Directed sequences pin the 0x60-then-bad-command case and the output-port write with bit 0 clear.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] MODE_RST = 8'h03;
  localparam logic [DW-1:0] STAT_RST = 8'h18;
  localparam logic [DW-1:0] OUTP_RST = 8'hCF;

  localparam int MODE_KDIS_BIT = 4;
  localparam int MODE_MDIS_BIT = 5;
  localparam int MODE_XLAT_BIT = 6;
  localparam int STAT_TEST_BIT = 2;
  localparam int OUTP_RUN_BIT  = 0;
  localparam int OUTP_A20_BIT  = 1;

  localparam logic [3:0] PULSE_NIB = 4'hF;

  typedef enum logic [2:0] {
    PEND_NONE,
    PEND_MODE,
    PEND_OUTP,
    PEND_KQ,
    PEND_AQ,
    PEND_MOUSE
  } pend_t;

  typedef enum logic [3:0] {
    ACT_BAD,
    ACT_RD_MODE,
    ACT_ARM,
    ACT_MDIS_SET,
    ACT_MDIS_CLR,
    ACT_KDIS_SET,
    ACT_KDIS_CLR,
    ACT_REPLY,
    ACT_SELFTEST,
    ACT_RD_OUTP,
    ACT_A20_ON,
    ACT_A20_OFF,
    ACT_SYSRST,
    ACT_NOP
  } act_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [DW-1:0] cmd,
  output act_t          act,
  output pend_t         arm_tgt,
  output logic [DW-1:0] reply
);
  always_comb begin
    act     = ACT_BAD;
    arm_tgt = PEND_NONE;
    reply   = '0;
    if (cmd[DW-1 -: 4] == PULSE_NIB) begin
      act = cmd[0] ? ACT_NOP : ACT_SYSRST;
    end else begin
      case (cmd)
        8'h20: act = ACT_RD_MODE;
        8'h60: begin act = ACT_ARM; arm_tgt = PEND_MODE;  end
        8'hD1: begin act = ACT_ARM; arm_tgt = PEND_OUTP;  end
        8'hD2: begin act = ACT_ARM; arm_tgt = PEND_KQ;    end
        8'hD3: begin act = ACT_ARM; arm_tgt = PEND_AQ;    end
        8'hD4: begin act = ACT_ARM; arm_tgt = PEND_MOUSE; end
        8'hA7: act = ACT_MDIS_SET;
        8'hA8: act = ACT_MDIS_CLR;
        8'hAD: act = ACT_KDIS_SET;
        8'hAE: act = ACT_KDIS_CLR;
        8'hA9, 8'hAB: begin act = ACT_REPLY; reply = 8'h00; end
        8'hC0: begin act = ACT_REPLY; reply = 8'h80; end
        8'hAA: begin act = ACT_SELFTEST; reply = 8'h55; end
        8'hD0: act = ACT_RD_OUTP;
        8'hDF: act = ACT_A20_ON;
        8'hDD: act = ACT_A20_OFF;
        default: act = ACT_BAD;
      endcase
    end
  end
endmodule

// File: rtl/kbc_next_state.sv
module kbc_next_state
  import kbc_pkg::*;
(
  input  logic          wr,
  input  logic          sel_cmd,
  input  logic [DW-1:0] wdata,
  input  act_t          act,
  input  pend_t         arm_tgt,
  input  logic [DW-1:0] reply,
  input  logic [DW-1:0] mode_cur,
  input  logic [DW-1:0] stat_cur,
  input  logic [DW-1:0] outp_cur,
  input  logic          a20_cur,
  input  logic          xlat_cur,
  input  pend_t         pend_cur,
  output logic [DW-1:0] mode_nxt,
  output logic [DW-1:0] stat_nxt,
  output logic [DW-1:0] outp_nxt,
  output logic          a20_nxt,
  output logic          xlat_nxt,
  output pend_t         pend_nxt,
  output logic          kenq_nxt,
  output logic          aenq_nxt,
  output logic          kfwd_nxt,
  output logic          mfwd_nxt,
  output logic          rst_nxt,
  output logic          bad_nxt,
  output logic [DW-1:0] byte_nxt
);
  always_comb begin
    mode_nxt = mode_cur;
    stat_nxt = stat_cur;
    outp_nxt = outp_cur;
    a20_nxt  = a20_cur;
    xlat_nxt = xlat_cur;
    pend_nxt = pend_cur;
    kenq_nxt = 1'b0;
    aenq_nxt = 1'b0;
    kfwd_nxt = 1'b0;
    mfwd_nxt = 1'b0;
    rst_nxt  = 1'b0;
    bad_nxt  = 1'b0;
    byte_nxt = '0;
    if (wr && sel_cmd) begin
      case (act)
        ACT_RD_MODE:  begin kenq_nxt = 1'b1; byte_nxt = mode_cur; end
        ACT_ARM:      pend_nxt = arm_tgt;
        ACT_MDIS_SET: mode_nxt[MODE_MDIS_BIT] = 1'b1;
        ACT_MDIS_CLR: mode_nxt[MODE_MDIS_BIT] = 1'b0;
        ACT_KDIS_SET: mode_nxt[MODE_KDIS_BIT] = 1'b1;
        ACT_KDIS_CLR: mode_nxt[MODE_KDIS_BIT] = 1'b0;
        ACT_REPLY:    begin kenq_nxt = 1'b1; byte_nxt = reply; end
        ACT_SELFTEST: begin
          stat_nxt[STAT_TEST_BIT] = 1'b1;
          kenq_nxt = 1'b1;
          byte_nxt = reply;
        end
        ACT_RD_OUTP:  begin kenq_nxt = 1'b1; byte_nxt = outp_cur; end
        ACT_A20_ON:   begin a20_nxt = 1'b1; outp_nxt[OUTP_A20_BIT] = 1'b1; end
        ACT_A20_OFF:  begin a20_nxt = 1'b0; outp_nxt[OUTP_A20_BIT] = 1'b0; end
        ACT_SYSRST:   rst_nxt = 1'b1;
        ACT_NOP:      ;
        default:      bad_nxt = 1'b1;
      endcase
    end else if (wr) begin
      pend_nxt = PEND_NONE;
      case (pend_cur)
        PEND_MODE: begin
          mode_nxt = wdata;
          xlat_nxt = wdata[MODE_XLAT_BIT];
        end
        PEND_OUTP: begin
          outp_nxt = wdata;
          a20_nxt  = wdata[OUTP_A20_BIT];
          rst_nxt  = ~wdata[OUTP_RUN_BIT];
        end
        PEND_KQ:    begin kenq_nxt = 1'b1; byte_nxt = wdata; end
        PEND_AQ:    begin aenq_nxt = 1'b1; byte_nxt = wdata; end
        PEND_MOUSE: begin mfwd_nxt = 1'b1; byte_nxt = wdata; end
        default:    begin kfwd_nxt = 1'b1; byte_nxt = wdata; end
      endcase
    end
  end
endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [DW-1:0] mode_nxt,
  input  logic [DW-1:0] stat_nxt,
  input  logic [DW-1:0] outp_nxt,
  input  logic          a20_nxt,
  input  logic          xlat_nxt,
  input  pend_t         pend_nxt,
  input  logic          kenq_nxt,
  input  logic          aenq_nxt,
  input  logic          kfwd_nxt,
  input  logic          mfwd_nxt,
  input  logic          rst_nxt,
  input  logic          bad_nxt,
  input  logic [DW-1:0] byte_nxt,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] outp_q,
  output logic          a20_q,
  output logic          xlat_q,
  output pend_t         pend_q,
  output logic          kenq_q,
  output logic          aenq_q,
  output logic          kfwd_q,
  output logic          mfwd_q,
  output logic          rst_q,
  output logic          bad_q,
  output logic [DW-1:0] byte_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      stat_q <= STAT_RST;
      outp_q <= OUTP_RST;
      a20_q  <= OUTP_RST[OUTP_A20_BIT];
      xlat_q <= MODE_RST[MODE_XLAT_BIT];
      pend_q <= PEND_NONE;
    end else if (upd_en) begin
      mode_q <= mode_nxt;
      stat_q <= stat_nxt;
      outp_q <= outp_nxt;
      a20_q  <= a20_nxt;
      xlat_q <= xlat_nxt;
      pend_q <= pend_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kenq_q <= 1'b0;
      aenq_q <= 1'b0;
      kfwd_q <= 1'b0;
      mfwd_q <= 1'b0;
      rst_q  <= 1'b0;
      bad_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      kenq_q <= kenq_nxt;
      aenq_q <= aenq_nxt;
      kfwd_q <= kfwd_nxt;
      mfwd_q <= mfwd_nxt;
      rst_q  <= rst_nxt;
      bad_q  <= bad_nxt;
      byte_q <= byte_nxt;
    end
  end
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_sel_cmd,
  input  logic [DW-1:0] host_wdata,
  output logic          kbd_enq,
  output logic          aux_enq,
  output logic          kbd_fwd,
  output logic          mouse_fwd,
  output logic [DW-1:0] out_byte,
  output logic          sys_rst_req,
  output logic          bad_cmd,
  output logic          a20_gate,
  output logic          xlat_en,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] outport_q
);
  act_t          dec_act;
  pend_t         dec_tgt;
  logic [DW-1:0] dec_reply;
  pend_t         pend_q;

  logic [DW-1:0] mode_n, stat_n, outp_n, byte_n;
  logic          a20_n, xlat_n;
  pend_t         pend_n;
  logic          kenq_n, aenq_n, kfwd_n, mfwd_n, rst_n_req, bad_n;

  kbc_cmd_decode u_dec (
    .cmd     (host_wdata),
    .act     (dec_act),
    .arm_tgt (dec_tgt),
    .reply   (dec_reply)
  );

  kbc_next_state u_nxt (
    .wr       (host_wr),
    .sel_cmd  (host_sel_cmd),
    .wdata    (host_wdata),
    .act      (dec_act),
    .arm_tgt  (dec_tgt),
    .reply    (dec_reply),
    .mode_cur (mode_q),
    .stat_cur (status_q),
    .outp_cur (outport_q),
    .a20_cur  (a20_gate),
    .xlat_cur (xlat_en),
    .pend_cur (pend_q),
    .mode_nxt (mode_n),
    .stat_nxt (stat_n),
    .outp_nxt (outp_n),
    .a20_nxt  (a20_n),
    .xlat_nxt (xlat_n),
    .pend_nxt (pend_n),
    .kenq_nxt (kenq_n),
    .aenq_nxt (aenq_n),
    .kfwd_nxt (kfwd_n),
    .mfwd_nxt (mfwd_n),
    .rst_nxt  (rst_n_req),
    .bad_nxt  (bad_n),
    .byte_nxt (byte_n)
  );

  kbc_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (host_wr),
    .mode_nxt (mode_n),
    .stat_nxt (stat_n),
    .outp_nxt (outp_n),
    .a20_nxt  (a20_n),
    .xlat_nxt (xlat_n),
    .pend_nxt (pend_n),
    .kenq_nxt (kenq_n),
    .aenq_nxt (aenq_n),
    .kfwd_nxt (kfwd_n),
    .mfwd_nxt (mfwd_n),
    .rst_nxt  (rst_n_req),
    .bad_nxt  (bad_n),
    .byte_nxt (byte_n),
    .mode_q   (mode_q),
    .stat_q   (status_q),
    .outp_q   (outport_q),
    .a20_q    (a20_gate),
    .xlat_q   (xlat_en),
    .pend_q   (pend_q),
    .kenq_q   (kbd_enq),
    .aenq_q   (aux_enq),
    .kfwd_q   (kbd_fwd),
    .mfwd_q   (mouse_fwd),
    .rst_q    (sys_rst_req),
    .bad_q    (bad_cmd),
    .byte_q   (out_byte)
  );
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk
  import kbc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_sel_cmd,
  input logic [DW-1:0] host_wdata,
  input logic          kbd_enq,
  input logic          aux_enq,
  input logic          kbd_fwd,
  input logic          mouse_fwd,
  input logic [DW-1:0] out_byte,
  input logic          sys_rst_req,
  input logic          bad_cmd,
  input logic          a20_gate,
  input logic          xlat_en,
  input logic [DW-1:0] mode_q,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] outport_q
);
  logic any_strobe;
  logic is_arm;
  assign any_strobe = kbd_enq | aux_enq | kbd_fwd | mouse_fwd | sys_rst_req | bad_cmd;
  assign is_arm = (host_wdata == 8'h60) || (host_wdata == 8'hD1) || (host_wdata == 8'hD2) ||
                  (host_wdata == 8'hD3) || (host_wdata == 8'hD4);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_enq, aux_enq, kbd_fwd, mouse_fwd, bad_cmd})); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> !any_strobe); // R12

  AST_BYTE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(kbd_enq | aux_enq | kbd_fwd | mouse_fwd) |-> out_byte == '0); // R12

  AST_ARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel_cmd && is_arm |=> !any_strobe); // R3

  AST_PULSE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel_cmd && host_wdata[7:4] == PULSE_NIB && !host_wdata[0]
    |=> sys_rst_req); // R7

  AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> $stable(mode_q) && $stable(status_q) && $stable(outport_q)); // R11

  AST_A20_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    a20_gate == outport_q[OUTP_A20_BIT]); // R8

  AST_XLAT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_en == mode_q[MODE_XLAT_BIT]); // R10

  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~(8'h01 << STAT_TEST_BIT)) == STAT_RST); // R6
endmodule

bind kbc_host_if kbc_host_if_chk u_chk (.*);

// File: tb/tb_kbc_host_if.sv
`timescale 1ns/100ps
module tb_kbc_host_if;
  logic       clk;
  logic       rst_n;
  logic       host_wr;
  logic       host_sel_cmd;
  logic [7:0] host_wdata;
  logic       kbd_enq, aux_enq, kbd_fwd, mouse_fwd, sys_rst_req, bad_cmd;
  logic       a20_gate, xlat_en;
  logic [7:0] out_byte, mode_q, status_q, outport_q;

  kbc_host_if dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel_cmd(host_sel_cmd),
    .host_wdata(host_wdata), .kbd_enq(kbd_enq), .aux_enq(aux_enq),
    .kbd_fwd(kbd_fwd), .mouse_fwd(mouse_fwd), .out_byte(out_byte),
    .sys_rst_req(sys_rst_req), .bad_cmd(bad_cmd), .a20_gate(a20_gate),
    .xlat_en(xlat_en), .mode_q(mode_q), .status_q(status_q), .outport_q(outport_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // reference model state
  logic [7:0] m_mode, m_stat, m_outp;
  logic       m_a20, m_xlat;
  int         m_pend;

  function automatic logic [39:0] observe();
    logic [7:0] b;
    b = (kbd_enq | aux_enq | kbd_fwd | mouse_fwd) ? out_byte : 8'h00;
    return {kbd_enq, aux_enq, kbd_fwd, mouse_fwd, sys_rst_req, bad_cmd,
            b, mode_q, status_q, outport_q, a20_gate, xlat_en};
  endfunction

  task automatic check(string tag, logic [39:0] got, logic [39:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 8'h03; m_stat = 8'h18; m_outp = 8'hCF;
    m_a20 = 1'b1; m_xlat = 1'b0; m_pend = 0;
  endtask

  task automatic apply(bit sel, logic [7:0] d);
    logic ek, ea, ef, em, er, ebad;
    logic [7:0] eb;
    string tag;
    ek = 0; ea = 0; ef = 0; em = 0; er = 0; ebad = 0; eb = 8'h00; tag = "R4";
    if (sel) begin
      if (d[7:4] == 4'hF) begin
        tag = "R7"; er = ~d[0];
      end else begin
        case (d)
          8'h20: begin tag = "R2"; ek = 1; eb = m_mode; end
          8'h60: begin tag = "R3"; m_pend = 1; end
          8'hD1: begin tag = "R3"; m_pend = 2; end
          8'hD2: begin tag = "R3"; m_pend = 3; end
          8'hD3: begin tag = "R3"; m_pend = 4; end
          8'hD4: begin tag = "R3"; m_pend = 5; end
          8'hA7: begin tag = "R5"; m_mode = m_mode | 8'h20; end
          8'hA8: begin tag = "R5"; m_mode = m_mode & 8'hDF; end
          8'hAD: begin tag = "R5"; m_mode = m_mode | 8'h10; end
          8'hAE: begin tag = "R5"; m_mode = m_mode & 8'hEF; end
          8'hA9, 8'hAB: begin tag = "R6"; ek = 1; eb = 8'h00; end
          8'hC0: begin tag = "R6"; ek = 1; eb = 8'h80; end
          8'hAA: begin tag = "R6"; ek = 1; eb = 8'h55; m_stat = m_stat | 8'h04; end
          8'hD0: begin tag = "R6"; ek = 1; eb = m_outp; end
          8'hDF: begin tag = "R8"; m_outp = m_outp | 8'h02; m_a20 = 1; end
          8'hDD: begin tag = "R8"; m_outp = m_outp & 8'hFD; m_a20 = 0; end
          default: begin tag = "R11"; ebad = 1; end
        endcase
      end
    end else begin
      case (m_pend)
        1: begin tag = "R10"; m_mode = d; m_xlat = d[6]; end
        2: begin tag = "R9"; m_outp = d; m_a20 = d[1]; er = ~d[0]; end
        3: begin tag = "R3"; ek = 1; eb = d; end
        4: begin tag = "R3"; ea = 1; eb = d; end
        5: begin tag = "R3"; em = 1; eb = d; end
        default: begin tag = "R4"; ef = 1; eb = d; end
      endcase
      m_pend = 0;
    end
    @(negedge clk);
    host_wr = 1'b1; host_sel_cmd = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_sel_cmd = 1'b0; host_wdata = 8'h00;
    check(tag, observe(), {ek, ea, ef, em, er, ebad, eb, m_mode, m_stat, m_outp, m_a20, m_xlat});
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R12", observe(), {6'b0, 8'h00, m_mode, m_stat, m_outp, m_a20, m_xlat});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  logic [7:0] cmd_pool [0:29];

  initial begin
    cmd_pool = '{8'h20, 8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hA7, 8'hA8, 8'hAD, 8'hAE,
                 8'hA9, 8'hAB, 8'hC0, 8'hAA, 8'hD0, 8'hDF, 8'hDD, 8'hF0, 8'hFE, 8'hFF,
                 8'hF7, 8'hF3, 8'h00, 8'h55, 8'hA1, 8'hD5, 8'hDE, 8'hEF, 8'h60, 8'hD1};
    host_wr = 0; host_sel_cmd = 0; host_wdata = 0;
    rst_n = 0;
    model_reset();
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", observe(), {6'b0, 8'h00, 8'h03, 8'h18, 8'hCF, 1'b1, 1'b0});

    apply(1, 8'h20);                     // R2 reads reset mode
    apply(0, 8'h3C);                     // R4 forward
    apply(1, 8'h60); apply(0, 8'h47);    // R10 mode write, xlat on
    apply(1, 8'h20);                     // R2 reads new mode
    apply(1, 8'hA7); apply(1, 8'hAD);    // R5
    apply(1, 8'hA8); apply(1, 8'hAE);    // R5
    apply(1, 8'hA9); apply(1, 8'hAB); apply(1, 8'hC0); apply(1, 8'hAA); // R6
    apply(1, 8'hDD); apply(1, 8'hD0);    // R8 then R6 reads outport
    apply(1, 8'hDF);                     // R8
    apply(1, 8'hFE); apply(1, 8'hFF); apply(1, 8'hF1); apply(1, 8'hF0); // R7
    apply(1, 8'hD1); apply(0, 8'h0C);    // R9 reset bit clear, A20 low
    apply(1, 8'hD1); apply(0, 8'hCF);    // R9 restore
    apply(1, 8'hD2); apply(0, 8'h11);    // R3 keyboard queue
    apply(1, 8'hD3); apply(0, 8'h22);    // R3 aux queue
    apply(1, 8'hD4); apply(0, 8'h33);    // R3 mouse forward
    apply(0, 8'h44);                     // R3 latch cleared -> forward
    apply(1, 8'h60); apply(1, 8'h01); apply(0, 8'h00); // R11 bad keeps pending
    apply(1, 8'h60); apply(1, 8'hA9); apply(0, 8'h03); // R3 immediate cmd keeps pending
    idle_check();                        // R12

    for (int i = 0; i < 4000; i++) begin
      bit sel;
      logic [7:0] d;
      sel = ($urandom % 2) == 0;
      if (sel && ($urandom % 4) != 0) d = cmd_pool[$urandom % 30];
      else d = 8'($urandom);
      apply(sel, d);
      if ((i % 97) == 0) idle_check();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule